// File: doc/BRIEF.md
# Monotonicity Compensation Codeword Mapper

This block sits in front of a digitally-controlled oscillator whose delay line is built from binary-weighted segments. Under process, voltage and temperature drift the segments stop halving cleanly, so a plain binary codeword no longer gives a period that rises with the code. The mapper restores that ordering. For each segment index n it holds a compensation value written by a calibration engine, counts how many of that segment's delay gaps the user codeword has crossed, and adds the count times the compensation value to the codeword. The widened result is what the oscillator receives.

The gap count for segment n is computed without division as (C >> (n+1)) plus bit n of C. The per-segment products are formed in the first pipeline stage, and the sum is reduced and saturated in the second. A test-mode select lets a directly supplied codeword bypass the mapping, so the calibration engine can drive the oscillator while it measures. With all compensation values at their reset value of zero, the mapper passes the user codeword through unchanged.

Top module: `mono_cw_mapper`

## Requirements
- R1: After reset, out_valid is 0, out_cw is 0, ovf_flag is 0, and every compensation value is 0.
- R2: With all compensation values zero, a valid normal-mode input C produces out_cw equal to C zero-extended to K+4 bits.
- R3: In normal mode out_cw equals C plus the sum over n = 0..K-1 of g(n,C) times comp[n], where g(n,C) = floor((C - 2^n) / 2^(n+1)) + 1 when C >= 2^n and 0 otherwise.
- R4: out_valid is in_valid delayed by exactly two clock cycles, and back-to-back inputs each produce their own result two cycles later.
- R5: When the normal-mode sum exceeds 2^(K+4) - 1, out_cw is all ones.
- R6: ovf_flag rises in the cycle a saturated normal-mode result is presented and then stays 1 until reset.
- R7: With test_mode = 1, out_cw equals test_cw sampled with the input, regardless of user_cw and the compensation values, and ovf_flag is not changed.
- R8: A write with cal_we = 1 replaces only comp[cal_idx]; a write with cal_idx >= K has no effect on any result.
- R9: A compensation write is used by any input sampled on a later clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_we | input | 1 | Compensation value write strobe |
| cal_idx | input | 3 | Segment index of the write |
| cal_val | input | 5 | Compensation value written |
| test_mode | input | 1 | 1 = bypass, pass test_cw; 0 = mapped user codeword |
| test_cw | input | 10 | Codeword passed through in test mode |
| in_valid | input | 1 | Input sample valid |
| user_cw | input | 6 | User frequency control codeword |
| out_valid | output | 1 | Result valid, two cycles after in_valid |
| out_cw | output | 10 | Codeword applied to the oscillator |
| ovf_flag | output | 1 | Sticky saturation flag |

## Verification
Every user codeword from 0 to 63 is swept under four compensation sets: all zero, which separates a pure pass-through from any stray offset; distinct small values per segment, which exposes a wrong gap count or a swapped segment index; a single nonzero segment, which shows that a segment contributes only on the codes whose bit pattern crosses its gaps; and all values at maximum, which drives the upper codes into saturation and sets the sticky flag. Test-mode samples with nonzero compensation show the bypass ignores mapping and leaves the flag alone, an out-of-range write is shown to leave results unchanged, and a streaming burst confirms the two-cycle latency for consecutive inputs.

// File: rtl/cwmap_pkg.sv
package cwmap_pkg;

    typedef enum logic {
        MAP_NORMAL = 1'b0,
        MAP_BYPASS = 1'b1
    } map_mode_e;

endpackage

// File: rtl/comp_bank.sv
module comp_bank #(
    parameter int K    = 6,
    parameter int CW   = 5,
    parameter int SELW = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [SELW-1:0]        sel,
    input  logic [CW-1:0]          val,
    output logic [K-1:0][CW-1:0]   comp
);

    logic [K-1:0][CW-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int n = 0; n < K; n++) begin
            if (we && (32'(sel) == n)) begin
                bank_d[n] = val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign comp = bank_q;

    // R8
    sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (32'(sel) >= K)) |=> $stable(bank_q));

endmodule

// File: rtl/gap_term.sv
module gap_term #(
    parameter int K   = 6,
    parameter int CW  = 5,
    parameter int IDX = 0,
    localparam int TW = K + CW
) (
    input  logic [K-1:0]  ucw,
    input  logic [CW-1:0] comp,
    output logic [TW-1:0] term
);

    logic [K-1:0] gaps;

    always_comb begin
        gaps = (ucw >> (IDX + 1)) + {{(K-1){1'b0}}, ucw[IDX]};
        term = TW'(gaps) * TW'(comp);
    end

endmodule

// File: rtl/sum_sat.sv
module sum_sat #(
    parameter int K  = 6,
    parameter int TW = 11,
    parameter int OW = 10,
    localparam int SUMW = TW + $clog2(K) + 1
) (
    input  logic [K-1:0][TW-1:0] terms,
    input  logic [K-1:0]         ucw,
    output logic [OW-1:0]        res,
    output logic                 sat
);

    logic [SUMW-1:0] acc;

    always_comb begin
        acc = SUMW'(ucw);
        for (int n = 0; n < K; n++) begin
            acc = acc + SUMW'(terms[n]);
        end
        sat = |acc[SUMW-1:OW];
        res = sat ? '1 : acc[OW-1:0];
    end

endmodule

// File: rtl/mono_cw_mapper.sv
module mono_cw_mapper #(
    parameter int K    = 6,
    parameter int CW   = 5,
    localparam int SELW = (K > 1) ? $clog2(K) : 1,
    localparam int OW   = K + 4,
    localparam int TW   = K + CW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cal_we,
    input  logic [SELW-1:0] cal_idx,
    input  logic [CW-1:0]   cal_val,
    input  logic            test_mode,
    input  logic [OW-1:0]   test_cw,
    input  logic            in_valid,
    input  logic [K-1:0]    user_cw,
    output logic            out_valid,
    output logic [OW-1:0]   out_cw,
    output logic            ovf_flag
);
    import cwmap_pkg::*;

    typedef struct packed {
        logic                 vld;
        map_mode_e            mode;
        logic [K-1:0]         ucw;
        logic [OW-1:0]        tcw;
        logic [K-1:0][TW-1:0] terms;
    } prod_st_t;

    typedef struct packed {
        logic          vld;
        map_mode_e     mode;
        logic [OW-1:0] cw;
        logic          ovf;
    } out_st_t;

    logic [K-1:0][CW-1:0] comp;
    logic [K-1:0][TW-1:0] terms_now;
    logic [OW-1:0]        mapped;
    logic                 mapped_sat;
    prod_st_t             p_d, p_q;
    out_st_t              o_d, o_q;

    comp_bank #(.K(K), .CW(CW), .SELW(SELW)) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cal_we),
        .sel  (cal_idx),
        .val  (cal_val),
        .comp (comp)
    );

    for (genvar n = 0; n < K; n++) begin : g_seg
        gap_term #(.K(K), .CW(CW), .IDX(n)) u_term (
            .ucw (user_cw),
            .comp(comp[n]),
            .term(terms_now[n])
        );
    end

    sum_sat #(.K(K), .TW(TW), .OW(OW)) u_sum (
        .terms(p_q.terms),
        .ucw  (p_q.ucw),
        .res  (mapped),
        .sat  (mapped_sat)
    );

    always_comb begin
        p_d.vld   = in_valid;
        p_d.mode  = test_mode ? MAP_BYPASS : MAP_NORMAL;
        p_d.ucw   = user_cw;
        p_d.tcw   = test_cw;
        p_d.terms = terms_now;

        o_d.vld  = p_q.vld;
        o_d.mode = p_q.mode;
        o_d.cw   = (p_q.mode == MAP_BYPASS) ? p_q.tcw : mapped;
        o_d.ovf  = o_q.ovf | (p_q.vld && (p_q.mode == MAP_NORMAL) && mapped_sat);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
            o_q <= '0;
        end else begin
            p_q <= p_d;
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.vld;
    assign out_cw    = o_q.cw;
    assign ovf_flag  = o_q.ovf;

    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n) age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    // R4
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R6
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    // R5
    sat_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (out_valid && (&out_cw)));

    // R3
    no_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q == 2'd2) && out_valid && (o_q.mode == MAP_NORMAL))
            |-> (out_cw >= OW'($past(user_cw, 2))));

    // R7
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q == 2'd2) && out_valid && (o_q.mode == MAP_BYPASS))
            |-> (out_cw == $past(test_cw, 2)));

endmodule

// File: tb/sim_mono_cw_mapper.sv
module sim_mono_cw_mapper;

    localparam int K  = 6;
    localparam int CW = 5;
    localparam int OW = K + 4;
    localparam int MAXO = (1 << OW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cal_we = 1'b0;
    logic [2:0]    cal_idx = '0;
    logic [CW-1:0] cal_val = '0;
    logic          test_mode = 1'b0;
    logic [OW-1:0] test_cw = '0;
    logic          in_valid = 1'b0;
    logic [K-1:0]  user_cw = '0;
    logic          out_valid;
    logic [OW-1:0] out_cw;
    logic          ovf_flag;

    int checks = 0;
    int errors = 0;
    int comps[K];
    bit ovf_model = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mono_cw_mapper #(.K(K), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cal_we(cal_we), .cal_idx(cal_idx),
        .cal_val(cal_val), .test_mode(test_mode), .test_cw(test_cw),
        .in_valid(in_valid), .user_cw(user_cw), .out_valid(out_valid),
        .out_cw(out_cw), .ovf_flag(ovf_flag)
    );

    function automatic int raw_sum(int c);
        int s = c;
        for (int n = 0; n < K; n++) begin
            int g = (c >= (1 << n)) ? ((c - (1 << n)) / (1 << (n + 1)) + 1) : 0;
            s += g * comps[n];
        end
        return s;
    endfunction

    function automatic int exp_cw(int c);
        int s = raw_sum(c);
        return (s > MAXO) ? MAXO : s;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_comp(int idx, int val);
        @(negedge clk);
        cal_we = 1'b1; cal_idx = 3'(idx); cal_val = CW'(val);
        if (idx < K) comps[idx] = val;
        @(negedge clk);
        cal_we = 1'b0;
    endtask

    task automatic run_one(string req, bit tm, int c, int tc);
        int exp;
        @(negedge clk);
        test_mode = tm; user_cw = K'(c); test_cw = OW'(tc); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        if (tm) exp = tc;
        else begin
            exp = exp_cw(c);
            if (raw_sum(c) > MAXO) ovf_model = 1;
        end
        check(req, int'(out_valid), 1);
        check(req, int'(out_cw), exp);
        check("R6", int'(ovf_flag), int'(ovf_model));
    endtask

    task automatic sweep(string req);
        for (int c = 0; c < (1 << K); c++) run_one(req, 1'b0, c, 0);
    endtask

    initial begin
        for (int n = 0; n < K; n++) comps[n] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_cw), 0);
        check("R1", int'(ovf_flag), 0);

        // R2 pass-through with zero compensation (R1 reset values in effect)
        sweep("R2");

        // R3 distinct per-segment values; R9 writes used right after
        for (int n = 0; n < K; n++) write_comp(n, n + 1);
        sweep("R3");

        // R7 bypass ignores mapping, leaves flag alone
        run_one("R7", 1'b1, 63, MAXO);
        run_one("R7", 1'b1, 5, 300);
        run_one("R7", 1'b1, 0, 0);

        // R3 single active segment
        for (int n = 0; n < K; n++) write_comp(n, 0);
        write_comp(3, 7);
        sweep("R3");

        // R8 out-of-range writes ignored
        write_comp(6, 31);
        write_comp(7, 31);
        run_one("R8", 1'b0, 63, 0);
        run_one("R8", 1'b0, 8, 0);
        run_one("R8", 1'b0, 7, 0);

        // R4 back-to-back stream
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check("R4", int'(out_valid), 1);
                check("R4", int'(out_cw), exp_cw(((i - 2) * 5) % 64));
            end
            test_mode = 1'b0; user_cw = K'((i * 5) % 64); in_valid = (i < 10);
        end
        @(negedge clk);
        check("R4", int'(out_valid), 0);

        // R5 saturation and R6 sticky flag
        for (int n = 0; n < K; n++) write_comp(n, 31);
        sweep("R5");
        run_one("R6", 1'b0, 0, 0);
        run_one("R7", 1'b1, 1, 17);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule